// File: doc/BRIEF.md
# Transmit Byte FIFO with Byte and Word Push Ports

This block is the transmit staging buffer between a register write path and a serial shifter. Software writes outgoing data through one of two push ports. The narrow port stores a single byte per write. The wide port stores a 32-bit word per write, split into four bytes. All bytes land in one byte-granular store. The serializer drains that store one byte per pop request, and it sees the head byte combinationally.

A status word reports the free space in bytes in its upper half, so software can size its next burst of writes. Three flags go to the interrupt logic. Empty and full follow the occupancy. Overrun is a one-cycle error pulse, raised whenever a push is dropped for lack of room. Address decoding and DMA sit outside this block.

Top module: `tx_byte_fifo`

## Requirements
- R1: A strobe on byte_wr_i (with word_wr_i low) stores exactly one byte, taken from wdata_i[7:0]; bits [31:8] are ignored.
- R2: A strobe on word_wr_i stores four bytes in least-significant-first order: wdata_i[7:0] leaves first, then [15:8], then [23:16], then [31:24].
- R3: status_o[31:16] equals DEPTH minus the current occupancy, and status_o[15:0] always reads zero; it reflects a push or pop in the cycle after the clock edge that performed it.
- R4: empty_o is high exactly when the occupancy is zero, and full_o is high exactly when the occupancy equals DEPTH.
- R5: A word push that finds fewer than four free bytes is dropped whole, with no partial store; overrun_o is then high for exactly the one cycle after that edge.
- R6: A byte push into a full store is dropped, and overrun_o pulses for one cycle in the same way.
- R7: While the store is not empty, pop_data_o shows the oldest byte, and pop_i removes it at the clock edge. A pop while the store is empty has no effect.
- R8: When byte_wr_i and word_wr_i are both high in one cycle, the word is taken and the byte write is ignored, without an overrun.
- R9: When a push and a pop fall in the same cycle, the push is accepted or dropped based on the free space before the pop, and the occupancy changes by the bytes pushed minus the bytes popped.
- R10: After reset the store is empty, the free space is DEPTH and overrun_o is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| byte_wr_i | input | 1 | Push one byte from wdata_i[7:0] |
| word_wr_i | input | 1 | Push four bytes from wdata_i |
| wdata_i | input | 32 | Write data for either push port |
| pop_i | input | 1 | Serializer takes the head byte |
| pop_data_o | output | 8 | Head byte of the store |
| status_o | output | 32 | Free bytes in [31:16], zero below |
| empty_o | output | 1 | Store holds no bytes |
| full_o | output | 1 | Store holds DEPTH bytes |
| overrun_o | output | 1 | One-cycle pulse after a dropped push |

## Verification
The hardest case to reach is a word push that finds one to three free bytes. Without care it would be stored in part or would wrap over unread data. The bench fills the store with fifteen words and two single bytes to leave exactly two bytes free, then issues a word push. It checks that the free count does not move and that overrun pulses. It then tops up the store with bytes and drains it, to prove that no byte of the dropped word slipped in. A second hard case is a pop into a full store in the same cycle as a push. The bench checks that such a push is still refused, because acceptance is judged on the space before the pop.

// File: rtl/txf_pkg.sv
package txf_pkg;
  localparam int unsigned BYTES_PER_WORD = 4;
  localparam int unsigned FREE_LSB       = 16;
  localparam int unsigned FREE_W         = 16;
  typedef logic [7:0] byte_t;
endpackage

// File: rtl/tx_fifo_store.sv
module tx_fifo_store
  import txf_pkg::*;
#(
  parameter int unsigned DEPTH = 64
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        push_i,
  input  logic        push_word_i,
  input  logic [31:0] wdata_i,
  input  logic        pop_i,
  output byte_t       head_o
);
  localparam int unsigned AW = $clog2(DEPTH);

  byte_t          mem [DEPTH];
  byte_t          lane_byte [BYTES_PER_WORD];
  logic [AW-1:0]  wr_ptr_q, rd_ptr_q;

  for (genvar l = 0; l < BYTES_PER_WORD; l++) begin : g_lane
    assign lane_byte[l] = wdata_i[8*l +: 8];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_ptr_q <= '0;
      rd_ptr_q <= '0;
    end else begin
      if (push_i) wr_ptr_q <= wr_ptr_q + (push_word_i ? AW'(BYTES_PER_WORD) : AW'(1));
      if (pop_i)  rd_ptr_q <= rd_ptr_q + AW'(1);
    end
  end

  // Lane 0 serves both ports; upper lanes only on a word push
  always_ff @(posedge clk_i) begin
    for (int l = 0; l < BYTES_PER_WORD; l++) begin
      if (push_i && (l == 0 || push_word_i))
        mem[wr_ptr_q + AW'(l)] <= lane_byte[l];
    end
  end

  assign head_o = mem[rd_ptr_q];
endmodule

// File: rtl/tx_fifo_ctrl.sv
module tx_fifo_ctrl
  import txf_pkg::*;
#(
  parameter int unsigned DEPTH = 64
) (
  input  logic                        clk_i,
  input  logic                        rst_ni,
  input  logic                        byte_wr_i,
  input  logic                        word_wr_i,
  input  logic                        pop_i,
  output logic                        push_o,
  output logic                        push_word_o,
  output logic                        pop_o,
  output logic [$clog2(DEPTH+1)-1:0]  free_o,
  output logic                        overrun_o
);
  localparam int unsigned CW = $clog2(DEPTH + 1);

  logic [CW-1:0] count_q, count_d;
  logic          word_ok, byte_ok, drop;

  assign free_o  = CW'(DEPTH) - count_q;
  assign word_ok = word_wr_i && (free_o >= CW'(BYTES_PER_WORD));
  assign byte_ok = byte_wr_i && !word_wr_i && (free_o != '0);
  assign drop    = (word_wr_i && !word_ok) || (byte_wr_i && !word_wr_i && !byte_ok);

  assign push_o      = word_ok || byte_ok;
  assign push_word_o = word_ok;
  assign pop_o       = pop_i && (count_q != '0);

  always_comb begin
    count_d = count_q;
    if (word_ok) count_d = count_d + CW'(BYTES_PER_WORD);
    if (byte_ok) count_d = count_d + CW'(1);
    if (pop_o)   count_d = count_d - CW'(1);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      count_q   <= '0;
      overrun_o <= 1'b0;
    end else begin
      count_q   <= count_d;
      overrun_o <= drop;
    end
  end
endmodule

// File: rtl/tx_byte_fifo.sv
module tx_byte_fifo
  import txf_pkg::*;
#(
  parameter int unsigned DEPTH = 64
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        byte_wr_i,
  input  logic        word_wr_i,
  input  logic [31:0] wdata_i,
  input  logic        pop_i,
  output logic [7:0]  pop_data_o,
  output logic [31:0] status_o,
  output logic        empty_o,
  output logic        full_o,
  output logic        overrun_o
);
  localparam int unsigned CW = $clog2(DEPTH + 1);

  logic          push, push_word, pop_ok;
  logic [CW-1:0] free;

  tx_fifo_ctrl #(.DEPTH(DEPTH)) u_ctrl (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .byte_wr_i   (byte_wr_i),
    .word_wr_i   (word_wr_i),
    .pop_i       (pop_i),
    .push_o      (push),
    .push_word_o (push_word),
    .pop_o       (pop_ok),
    .free_o      (free),
    .overrun_o   (overrun_o)
  );

  tx_fifo_store #(.DEPTH(DEPTH)) u_store (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .push_i      (push),
    .push_word_i (push_word),
    .wdata_i     (wdata_i),
    .pop_i       (pop_ok),
    .head_o      (pop_data_o)
  );

  assign status_o = {FREE_W'(free), {FREE_LSB{1'b0}}};
  assign empty_o  = (free == CW'(DEPTH));
  assign full_o   = (free == '0);
endmodule

// File: rtl/tx_byte_fifo_chk.sv
module tx_byte_fifo_chk #(
  parameter int unsigned DEPTH = 64
) (
  input logic        clk_i,
  input logic        rst_ni,
  input logic        byte_wr_i,
  input logic        word_wr_i,
  input logic [31:0] wdata_i,
  input logic        pop_i,
  input logic [7:0]  pop_data_o,
  input logic [31:0] status_o,
  input logic        empty_o,
  input logic        full_o,
  input logic        overrun_o
);
  logic [15:0] free;
  assign free = status_o[31:16];

  a_r4_not_both: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(empty_o && full_o));

  a_r3_free_range: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (free <= 16'(DEPTH)) && (status_o[15:0] == 16'h0));

  a_r1_byte_take: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (byte_wr_i && !word_wr_i && !full_o && !pop_i) |=> (free == $past(free) - 16'd1) && !overrun_o);

  a_r2_word_take: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (word_wr_i && free >= 16'd4 && !pop_i) |=> (free == $past(free) - 16'd4) && !overrun_o);

  a_r5_word_drop: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (word_wr_i && free < 16'd4 && !pop_i) |=> overrun_o && $stable(free));

  a_r6_byte_drop: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (byte_wr_i && !word_wr_i && full_o && !pop_i) |=> overrun_o && full_o);

  a_r7_empty_pop: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pop_i && empty_o && !byte_wr_i && !word_wr_i) |=> empty_o);

  a_r7_pop_frees: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pop_i && !empty_o && !byte_wr_i && !word_wr_i) |=> (free == $past(free) + 16'd1));

  a_r5_pulse_cause: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(overrun_o) |-> ($past(byte_wr_i) || $past(word_wr_i)));
endmodule

bind tx_byte_fifo tx_byte_fifo_chk #(.DEPTH(DEPTH)) u_chk (.*);

// File: tb/tx_byte_fifo_bench.sv
module tx_byte_fifo_bench;
  localparam int DEPTH = 64;

  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        byte_wr_i = 1'b0, word_wr_i = 1'b0, pop_i = 1'b0;
  logic [31:0] wdata_i = '0;
  logic [7:0]  pop_data_o;
  logic [31:0] status_o;
  logic        empty_o, full_o, overrun_o;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #4 clk = ~clk;

  tx_byte_fifo #(.DEPTH(DEPTH)) u_tx_byte_fifo (
    .clk_i(clk), .rst_ni(rst_ni), .byte_wr_i(byte_wr_i), .word_wr_i(word_wr_i),
    .wdata_i(wdata_i), .pop_i(pop_i), .pop_data_o(pop_data_o), .status_o(status_o),
    .empty_o(empty_o), .full_o(full_o), .overrun_o(overrun_o)
  );

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic chk_free(input string tag, input int exp);
    chk(status_o == (32'(exp) << 16), tag, status_o, 32'(exp) << 16);
  endtask

  // One cycle of stimulus; returns sampled 1ns after the edge
  task automatic cyc(input bit b, input bit w, input logic [31:0] d, input bit p);
    byte_wr_i = b; word_wr_i = w; wdata_i = d; pop_i = p;
    @(posedge clk); #1;
    byte_wr_i = 0; word_wr_i = 0; pop_i = 0; wdata_i = '0;
  endtask

  task automatic pop_exp(input logic [7:0] exp, input string tag);
    chk(!empty_o && pop_data_o == exp, tag, pop_data_o, exp);
    cyc(0, 0, '0, 1);
  endtask

  function automatic logic [31:0] fill_word(input int k);
    return {8'(4*k+3), 8'(4*k+2), 8'(4*k+1), 8'(4*k)};
  endfunction

  task automatic t_reset;
    chk(empty_o, "R10 empty after reset", empty_o, 1);
    chk(!full_o, "R10 full low after reset", full_o, 0);
    chk(!overrun_o, "R10 overrun low after reset", overrun_o, 0);
    chk_free("R10 R3 free after reset", DEPTH);
  endtask

  task automatic t_byte;
    cyc(1, 0, 32'h1234_56A5, 0);
    chk_free("R1 R3 free after byte push", DEPTH - 1);
    chk(!empty_o && !overrun_o, "R1 R4 not empty", empty_o, 0);
    pop_exp(8'hA5, "R1 R7 byte data low bits");
    chk(empty_o, "R1 only one byte stored", empty_o, 1);
  endtask

  task automatic t_word;
    cyc(0, 1, 32'hDDCC_BBAA, 0);
    chk_free("R2 R3 free after word", DEPTH - 4);
    pop_exp(8'hAA, "R2 byte0");
    pop_exp(8'hBB, "R2 byte1");
    pop_exp(8'hCC, "R2 byte2");
    pop_exp(8'hDD, "R2 byte3");
    chk(empty_o, "R2 R4 empty after drain", empty_o, 1);
  endtask

  task automatic t_pop_empty;
    cyc(0, 0, '0, 1);
    chk(empty_o, "R7 pop on empty keeps empty", empty_o, 1);
    chk_free("R7 pop on empty free", DEPTH);
    cyc(1, 0, 32'h0000_0042, 0);
    pop_exp(8'h42, "R7 data after empty pop");
  endtask

  task automatic t_fill;
    for (int k = 0; k < DEPTH / 4; k++) cyc(0, 1, fill_word(k), 0);
    chk(full_o && !empty_o, "R4 full after fill", full_o, 1);
    chk_free("R3 free zero when full", 0);
    cyc(1, 0, 32'h0000_00EE, 0);
    chk(overrun_o, "R6 overrun on full byte push", overrun_o, 1);
    chk_free("R6 free unchanged", 0);
    cyc(0, 0, '0, 0);
    chk(!overrun_o, "R6 overrun one cycle", overrun_o, 0);
    cyc(0, 1, 32'hFFFF_FFFF, 0);
    chk(overrun_o, "R5 overrun on full word push", overrun_o, 1);
    // R9: pop and byte push together on full: push judged before pop
    cyc(1, 0, 32'h0000_0077, 1);
    chk(overrun_o, "R9 push refused despite pop", overrun_o, 1);
    chk_free("R9 free after pop only", 1);
    for (int i = 1; i < DEPTH; i++) pop_exp(8'(i), "R2 fill drain order");
    chk(empty_o, "R9 no stray byte stored", empty_o, 1);
  endtask

  task automatic t_partial;
    for (int k = 0; k < DEPTH / 4 - 1; k++) cyc(0, 1, fill_word(k), 0);
    cyc(1, 0, 32'h0000_00C1, 0);
    cyc(1, 0, 32'h0000_00C2, 0);
    chk_free("R3 two free", 2);
    cyc(0, 1, 32'h9988_7766, 0);
    chk(overrun_o, "R5 word dropped with two free", overrun_o, 1);
    chk_free("R5 no partial store", 2);
    cyc(1, 0, 32'h0000_00C3, 0);
    chk(!overrun_o, "R1 byte accepted with room", overrun_o, 0);
    cyc(1, 0, 32'h0000_00C4, 0);
    chk(full_o, "R4 full after top-up", full_o, 1);
    for (int i = 0; i < DEPTH - 4; i++) pop_exp(8'(i), "R5 drain words");
    pop_exp(8'hC1, "R5 tail byte1");
    pop_exp(8'hC2, "R5 tail byte2");
    pop_exp(8'hC3, "R5 tail byte3");
    pop_exp(8'hC4, "R5 tail byte4");
    chk(empty_o, "R5 empty after drain", empty_o, 1);
  endtask

  task automatic t_both;
    cyc(1, 1, 32'h4433_2211, 0);
    chk(!overrun_o, "R8 no overrun on dual strobe", overrun_o, 0);
    chk_free("R8 word taken only", DEPTH - 4);
    // R9: word push and pop together
    cyc(0, 1, 32'h8877_6655, 1);
    chk_free("R9 net three bytes", DEPTH - 7);
    pop_exp(8'h22, "R8 R9 order");
    pop_exp(8'h33, "R8 order");
    pop_exp(8'h44, "R8 order");
    pop_exp(8'h55, "R9 word after pop");
    pop_exp(8'h66, "R9 order");
    pop_exp(8'h77, "R9 order");
    pop_exp(8'h88, "R9 order");
    chk(empty_o, "R8 no extra byte", empty_o, 1);
  endtask

  initial begin
    #(8 * 200000);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_ni = 1'b1;
    @(posedge clk); #1;
    t_reset();
    t_byte();
    t_word();
    t_pop_empty();
    t_fill();
    t_partial();
    t_both();
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule